// File: doc/BRIEF.md
# Successive-Approximation Converter Capture Controller

This block sits on the host side of a 16-bit successive-approximation analog-to-digital converter that has a parallel result bus. It divides the system clock to produce the converter's conversion clock. On a sample request it pulls chip-select low, then drops the convert strobe for a programmed number of cycles. It then watches the converter's busy line. Once busy has been seen high and has fallen again, it reads the result with a read strobe.

The result is read in one of two ways, chosen at build time by a parameter. In word mode the controller reads all 16 data lines in a single read. In byte mode it makes two reads over the lower eight lines: the low byte with the byte-select line low, then the high byte with byte-select high. The two bytes are then joined into one word. The captured word is presented with a single-cycle valid flag and is passed through unchanged, in straight binary coding.

The controller never lets a read strobe fall inside a guard window before the convert strobe falls, or inside a short window after it. A request that arrives while the controller is busy is remembered and served later. A conversion whose busy line never falls is abandoned after a set number of conversion-clock edges, and an error pulse is raised.

Top module: `sar_capture_ctrl`

## Requirements
- R1: The conversion clock `adc_clk_o` is a free-running square wave. It toggles every `CLK_DIV_HALF` system cycles, so its period is `2*CLK_DIV_HALF` cycles.
- R2: A conversion starts with chip-select `adc_cs_n_o` low for at least one cycle before the convert strobe `adc_convst_n_o` falls. Chip-select stays low at that edge. The strobe then stays low for exactly `CONV_LOW_CYC` cycles.
- R3: The convert strobe never falls while `adc_busy_i` is high. The first read of a conversion starts only after busy has been observed high and has returned low.
- R4: At every falling edge of the convert strobe, the read strobe `adc_rd_n_o` has been high for at least `GUARD_CYC` preceding cycles. No read strobe goes low within `POST_CYC` cycles after that edge.
- R5: The read strobe is low only while chip-select is low, and each read lasts `RD_CYC` cycles. In word mode (`BYTE_MODE`=0) there is one read per conversion, with `adc_byte_o` low, and the sample is `adc_db_i[15:0]`.
- R6: In byte mode (`BYTE_MODE`=1) there are two reads per conversion. The first read has `adc_byte_o`=0, and `adc_db_i[7:0]` becomes sample bits 7:0. The second read has `adc_byte_o`=1, and `adc_db_i[7:0]` becomes sample bits 15:8. `adc_byte_o` never changes during a read, and `adc_db_i[15:8]` has no effect in this mode.
- R7: Each completed conversion produces exactly one single-cycle `smp_valid_o` pulse. `smp_o` carries the converter's code unchanged: 0x0000 for zero, 0x8000 for midscale, 0x7FFF for midscale minus one step, 0xFFFF for full scale minus one step.
- R8: A `req_i` pulse that arrives while a conversion or read is in progress, or during the guard window, is held pending. It is served by a later conversion without being lost.
- R9: If busy has not fallen within `TIMEOUT_CCLK` rising edges of the conversion clock after the strobe sequence starts, `timeout_o` pulses for one cycle. No `smp_valid_o` pulse is produced for that attempt, and the controller accepts new requests afterwards.
- R10: While and after reset, `adc_convst_n_o`, `adc_cs_n_o` and `adc_rd_n_o` are high, and `adc_byte_o`, `smp_valid_o` and `timeout_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Sample request pulse |
| adc_busy_i | input | 1 | Converter busy flag |
| adc_db_i | input | DATA_W | Converter parallel data bus |
| adc_clk_o | output | 1 | Conversion clock to converter |
| adc_convst_n_o | output | 1 | Convert strobe, active low |
| adc_cs_n_o | output | 1 | Chip-select, active low |
| adc_rd_n_o | output | 1 | Read strobe, active low |
| adc_byte_o | output | 1 | Byte select: 0 low byte, 1 high byte |
| smp_o | output | DATA_W | Captured sample, straight binary |
| smp_valid_o | output | 1 | One-cycle sample valid |
| timeout_o | output | 1 | One-cycle busy timeout error |

## Verification
The assertions check the pin protocol on every cycle:
- chip-select is already low when the strobe falls, and the strobe stays low for the exact width;
- no conversion starts while busy is high;
- the guard windows hold on both sides of the strobe;
- reads happen only under chip-select, and byte-select stays steady during a read;
- valid and timeout are single-cycle pulses.

Some behaviour only the bench scenarios can show, because it is seen at the ports of a behavioural converter. These are:
- that the assembled word matches the converter's codes, including the zero, midscale and full-scale codes;
- that the low byte is read before the high byte, and that the upper data lanes are ignored in byte mode;
- that a request raised during a conversion still produces a sample;
- that a hung busy line ends in a timeout pulse and is followed by a normal conversion.

// File: rtl/sar_cap_pkg.sv
package sar_cap_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CS_SETUP,
        S_CONV_LO,
        S_WAIT_BUSY,
        S_RD_LO,
        S_GAP,
        S_RD_HI,
        S_DONE
    } seq_state_e;

    typedef struct packed {
        logic convst_n;
        logic cs_n;
        logic rd_n;
        logic byte_sel;
    } bus_pins_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Pin levels decoded from the sequencer state.
    function automatic bus_pins_t pins_for(input seq_state_e st);
        bus_pins_t p;
        p = '{convst_n: 1'b1, cs_n: 1'b1, rd_n: 1'b1, byte_sel: 1'b0};
        case (st)
            S_CS_SETUP:  p.cs_n = 1'b0;
            S_CONV_LO:   begin p.cs_n = 1'b0; p.convst_n = 1'b0; end
            S_WAIT_BUSY: p.cs_n = 1'b0;
            S_RD_LO:     begin p.cs_n = 1'b0; p.rd_n = 1'b0; end
            S_GAP:       begin p.cs_n = 1'b0; p.byte_sel = 1'b1; end
            S_RD_HI:     begin p.cs_n = 1'b0; p.rd_n = 1'b0; p.byte_sel = 1'b1; end
            default:     ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sar_cclk_gen.sv
module sar_cclk_gen #(
    parameter int CLK_DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst,
    output logic cclk_o,
    output logic rise_o
);
    localparam int DW = (CLK_DIV_HALF > 1) ? $clog2(CLK_DIV_HALF) : 1;

    logic [DW-1:0] div_q;
    logic          cclk_q;
    logic          wrap;

    assign wrap = (div_q == DW'(CLK_DIV_HALF - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            cclk_q <= 1'b0;
        end else if (wrap) begin
            div_q  <= '0;
            cclk_q <= ~cclk_q;
        end else begin
            div_q  <= div_q + 1'b1;
        end
    end

    assign cclk_o = cclk_q;
    // High in the cycle whose closing edge raises the conversion clock.
    assign rise_o = wrap & ~cclk_q;
endmodule

// File: rtl/sar_busy_watch.sv
module sar_busy_watch #(
    parameter int TIMEOUT_CCLK = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic tick_i,
    input  logic busy_i,
    output logic seen_o,
    output logic expired_o
);
    localparam int TW = $clog2(TIMEOUT_CCLK + 1);

    logic [TW-1:0] tick_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (rst || !arm_i) begin
            tick_q <= '0;
            seen_q <= 1'b0;
        end else begin
            if (busy_i)
                seen_q <= 1'b1;
            if (tick_i && tick_q != TW'(TIMEOUT_CCLK))
                tick_q <= tick_q + 1'b1;
        end
    end

    assign seen_o    = seen_q | (arm_i & busy_i);
    assign expired_o = arm_i && (tick_q == TW'(TIMEOUT_CCLK));
endmodule

// File: rtl/sar_sample_asm.sv
module sar_sample_asm #(
    parameter int DATA_W    = 16,
    parameter int BYTE_MODE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_lo_i,
    input  logic              cap_hi_i,
    input  logic [DATA_W-1:0] db_i,
    output logic [DATA_W-1:0] word_o
);
    localparam int BYTE_W = DATA_W / 2;

    logic [DATA_W-1:0] word_q;

    generate
        if (BYTE_MODE != 0) begin : g_byte
            logic unused_hi_lanes;
            assign unused_hi_lanes = ^db_i[DATA_W-1:BYTE_W];
            always_ff @(posedge clk) begin
                if (rst) begin
                    word_q <= '0;
                end else begin
                    if (cap_lo_i)
                        word_q[BYTE_W-1:0] <= db_i[BYTE_W-1:0];
                    if (cap_hi_i)
                        word_q[DATA_W-1:BYTE_W] <= db_i[BYTE_W-1:0];
                end
            end
        end else begin : g_word
            always_ff @(posedge clk) begin
                if (rst)
                    word_q <= '0;
                else if (cap_lo_i || cap_hi_i)
                    word_q <= db_i;
            end
        end
    endgenerate

    assign word_o = word_q;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_cap_pkg::*;
#(
    parameter int BYTE_MODE    = 0,
    parameter int CONV_LOW_CYC = 3,
    parameter int GUARD_CYC    = 16,
    parameter int RD_CYC       = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req_i,
    input  logic      busy_i,
    input  logic      seen_i,
    input  logic      expired_i,
    output bus_pins_t pins_o,
    output logic      arm_o,
    output logic      cap_lo_o,
    output logic      cap_hi_o,
    output logic      valid_o,
    output logic      timeout_o
);
    localparam int CNT_MAX = max2(CONV_LOW_CYC, RD_CYC);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int GRD_W   = $clog2(GUARD_CYC + 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [GRD_W-1:0] since_rd_q;
    logic             pend_q;
    logic             tmo_q;
    logic             start, tmo, cap_lo, cap_hi;
    logic             guard_ok;
    bus_pins_t        pins;

    assign pins     = pins_for(state_q);
    assign guard_ok = (since_rd_q == GRD_W'(GUARD_CYC));

    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        tmo     = 1'b0;
        cap_lo  = 1'b0;
        cap_hi  = 1'b0;
        case (state_q)
            S_IDLE: begin
                if ((req_i || pend_q) && guard_ok && !busy_i) begin
                    state_d = S_CS_SETUP;
                    start   = 1'b1;
                end
            end
            S_CS_SETUP: state_d = S_CONV_LO;
            S_CONV_LO: begin
                if (cnt_q == CNT_W'(CONV_LOW_CYC - 1))
                    state_d = S_WAIT_BUSY;
            end
            S_WAIT_BUSY: begin
                if (seen_i && !busy_i) begin
                    state_d = S_RD_LO;
                end else if (expired_i) begin
                    state_d = S_IDLE;
                    tmo     = 1'b1;
                end
            end
            S_RD_LO: begin
                if (cnt_q == CNT_W'(RD_CYC - 1)) begin
                    cap_lo  = 1'b1;
                    state_d = (BYTE_MODE != 0) ? S_GAP : S_DONE;
                end
            end
            S_GAP: state_d = S_RD_HI;
            S_RD_HI: begin
                if (cnt_q == CNT_W'(RD_CYC - 1)) begin
                    cap_hi  = 1'b1;
                    state_d = S_DONE;
                end
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= S_IDLE;
            cnt_q      <= '0;
            since_rd_q <= GRD_W'(GUARD_CYC);
            pend_q     <= 1'b0;
            tmo_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
            if (!pins.rd_n)
                since_rd_q <= '0;
            else if (!guard_ok)
                since_rd_q <= since_rd_q + 1'b1;
            pend_q <= start ? 1'b0 : (pend_q | req_i);
            tmo_q  <= tmo;
        end
    end

    assign pins_o    = pins;
    assign arm_o     = (state_q == S_CONV_LO) || (state_q == S_WAIT_BUSY);
    assign cap_lo_o  = cap_lo;
    assign cap_hi_o  = cap_hi;
    assign valid_o   = (state_q == S_DONE);
    assign timeout_o = tmo_q;
endmodule

// File: rtl/sar_capture_ctrl.sv
module sar_capture_ctrl
    import sar_cap_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int BYTE_MODE    = 0,
    parameter int CLK_DIV_HALF = 4,
    parameter int CONV_LOW_CYC = 3,
    parameter int GUARD_CYC    = 16,
    parameter int POST_CYC     = 2,
    parameter int RD_CYC       = 4,
    parameter int TIMEOUT_CCLK = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              adc_busy_i,
    input  logic [DATA_W-1:0] adc_db_i,
    output logic              adc_clk_o,
    output logic              adc_convst_n_o,
    output logic              adc_cs_n_o,
    output logic              adc_rd_n_o,
    output logic              adc_byte_o,
    output logic [DATA_W-1:0] smp_o,
    output logic              smp_valid_o,
    output logic              timeout_o
);
    // POST_CYC is met structurally: reads wait for the busy line to fall,
    // which takes many conversion-clock edges. The checker enforces it.
    localparam int POST_CHK = POST_CYC;

    bus_pins_t pins;
    logic      cclk_rise, arm, seen, expired, cap_lo, cap_hi;

    sar_cclk_gen #(.CLK_DIV_HALF(CLK_DIV_HALF)) u_cclk (
        .clk    (clk),
        .rst    (rst),
        .cclk_o (adc_clk_o),
        .rise_o (cclk_rise)
    );

    sar_busy_watch #(.TIMEOUT_CCLK(TIMEOUT_CCLK)) u_watch (
        .clk       (clk),
        .rst       (rst),
        .arm_i     (arm),
        .tick_i    (cclk_rise),
        .busy_i    (adc_busy_i),
        .seen_o    (seen),
        .expired_o (expired)
    );

    sar_seq #(
        .BYTE_MODE    (BYTE_MODE),
        .CONV_LOW_CYC (CONV_LOW_CYC),
        .GUARD_CYC    (GUARD_CYC),
        .RD_CYC       (RD_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_i),
        .busy_i    (adc_busy_i),
        .seen_i    (seen),
        .expired_i (expired),
        .pins_o    (pins),
        .arm_o     (arm),
        .cap_lo_o  (cap_lo),
        .cap_hi_o  (cap_hi),
        .valid_o   (smp_valid_o),
        .timeout_o (timeout_o)
    );

    sar_sample_asm #(.DATA_W(DATA_W), .BYTE_MODE(BYTE_MODE)) u_asm (
        .clk      (clk),
        .rst      (rst),
        .cap_lo_i (cap_lo),
        .cap_hi_i (cap_hi),
        .db_i     (adc_db_i),
        .word_o   (smp_o)
    );

    assign adc_convst_n_o = pins.convst_n;
    assign adc_cs_n_o     = pins.cs_n;
    assign adc_rd_n_o     = pins.rd_n;
    assign adc_byte_o     = pins.byte_sel;
endmodule

// File: rtl/sar_capture_chk.sv
module sar_capture_chk #(
    parameter int CONV_LOW_CYC = 3,
    parameter int GUARD_CYC    = 16,
    parameter int POST_CYC     = 2
) (
    input logic clk,
    input logic rst,
    input logic adc_busy_i,
    input logic adc_convst_n_o,
    input logic adc_cs_n_o,
    input logic adc_rd_n_o,
    input logic adc_byte_o,
    input logic smp_valid_o,
    input logic timeout_o
);
    localparam logic [15:0] SAT = 16'hFFFF;

    logic [15:0] low_run, since_rd, since_cv;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run  <= '0;
            since_rd <= SAT;
            since_cv <= SAT;
        end else begin
            low_run  <= adc_convst_n_o ? 16'd0 : low_run + 16'd1;
            since_rd <= !adc_rd_n_o ? 16'd0 : ((since_rd == SAT) ? SAT : since_rd + 16'd1);
            since_cv <= !adc_convst_n_o ? 16'd0 : ((since_cv == SAT) ? SAT : since_cv + 16'd1);
        end
    end

    AST_CS_BEFORE_CONVST: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_convst_n_o) |-> (!adc_cs_n_o && $past(!adc_cs_n_o))); // R2
    AST_CONVST_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_convst_n_o) |-> (low_run == 16'(CONV_LOW_CYC))); // R2
    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_convst_n_o) |-> !adc_busy_i); // R3
    AST_GUARD_BEFORE: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_convst_n_o) |-> (since_rd >= 16'(GUARD_CYC))); // R4
    AST_GUARD_AFTER: assert property (@(posedge clk) disable iff (rst)
        !adc_rd_n_o |-> (since_cv >= 16'(POST_CYC))); // R4
    AST_RD_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        !adc_rd_n_o |-> !adc_cs_n_o); // R5
    AST_BYTE_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!adc_rd_n_o && $past(!adc_rd_n_o)) |-> $stable(adc_byte_o)); // R6
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        smp_valid_o |=> !smp_valid_o); // R7
    AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> !timeout_o); // R9
    AST_TIMEOUT_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> !smp_valid_o); // R9
endmodule

bind sar_capture_ctrl sar_capture_chk #(
    .CONV_LOW_CYC (CONV_LOW_CYC),
    .GUARD_CYC    (GUARD_CYC),
    .POST_CYC     (POST_CHK)
) u_chk (.*);

// File: tb/sar_capture_ctrl_bench.sv
`timescale 1ns/1ps

module adc_beh_model (
    input  logic        clk,
    input  logic        rst,
    input  logic        cclk,
    input  logic        convst_n,
    input  logic        cs_n,
    input  logic        rd_n,
    input  logic        byte_sel,
    input  logic        stuck,
    input  logic [15:0] code_i,
    output logic        busy,
    output logic [15:0] db,
    output int          nconv
);
    logic        cv_q, cclk_q, hang;
    logic [15:0] code;
    int          edges;

    always_ff @(posedge clk) begin
        if (rst) begin
            cv_q <= 1'b1; cclk_q <= 1'b0; hang <= 1'b0; busy <= 1'b0;
            code <= '0; edges <= 0; nconv <= 0;
        end else begin
            cv_q   <= convst_n;
            cclk_q <= cclk;
            if (!busy && cv_q && !convst_n && !cs_n) begin
                busy  <= 1'b1;
                edges <= 0;
                hang  <= stuck;
                code  <= code_i;
                if (!stuck) nconv <= nconv + 1;
            end else if (busy) begin
                if (hang) begin
                    if (!stuck) begin hang <= 1'b0; busy <= 1'b0; end
                end else if (cclk && !cclk_q) begin
                    if (edges == 15) busy <= 1'b0;
                    edges <= edges + 1;
                end
            end
        end
    end

    assign db = (!cs_n && !rd_n) ? (byte_sel ? {8'hA5, code[15:8]} : code) : 16'h0000;
endmodule

module sar_capture_ctrl_bench;
    localparam int HALF  = 4;
    localparam int CLOW  = 3;
    localparam int GUARD = 16;
    localparam int POST  = 2;
    localparam int RDC   = 4;
    localparam int TMO   = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [1:0]  req = '0, stuck = '0;
    logic [1:0]  cclk, convst_n, cs_n, rd_n, byte_sel, busy, valid, tmo;
    logic [15:0] db [2];
    logic [15:0] smp [2];
    logic [15:0] code [2];
    int          nconv [2];

    int n_chk = 0, n_fail = 0, cyc = 0;
    int nreq [2] = '{0, 0};
    int tmo_cnt [2] = '{0, 0};
    logic [15:0] q0 [$];
    logic [15:0] q1 [$];

    function automatic logic [15:0] code_of(input int k);
        case (k)
            0: return 16'h0000;
            1: return 16'h8000;
            2: return 16'h7FFF;
            3: return 16'hFFFF;
            default: return 16'(k * 40503 + 4660);
        endcase
    endfunction

    assign code[0] = code_of(nconv[0]);
    assign code[1] = code_of(nconv[1]);

    sar_capture_ctrl #(.BYTE_MODE(0), .CLK_DIV_HALF(HALF), .CONV_LOW_CYC(CLOW),
        .GUARD_CYC(GUARD), .POST_CYC(POST), .RD_CYC(RDC), .TIMEOUT_CCLK(TMO)) u_sar_capture_ctrl (
        .clk(clk), .rst(rst), .req_i(req[0]), .adc_busy_i(busy[0]), .adc_db_i(db[0]),
        .adc_clk_o(cclk[0]), .adc_convst_n_o(convst_n[0]), .adc_cs_n_o(cs_n[0]),
        .adc_rd_n_o(rd_n[0]), .adc_byte_o(byte_sel[0]), .smp_o(smp[0]),
        .smp_valid_o(valid[0]), .timeout_o(tmo[0]));

    sar_capture_ctrl #(.BYTE_MODE(1), .CLK_DIV_HALF(HALF), .CONV_LOW_CYC(CLOW),
        .GUARD_CYC(GUARD), .POST_CYC(POST), .RD_CYC(RDC), .TIMEOUT_CCLK(TMO)) u_sar_capture_ctrl_byte (
        .clk(clk), .rst(rst), .req_i(req[1]), .adc_busy_i(busy[1]), .adc_db_i(db[1]),
        .adc_clk_o(cclk[1]), .adc_convst_n_o(convst_n[1]), .adc_cs_n_o(cs_n[1]),
        .adc_rd_n_o(rd_n[1]), .adc_byte_o(byte_sel[1]), .smp_o(smp[1]),
        .smp_valid_o(valid[1]), .timeout_o(tmo[1]));

    adc_beh_model u_adc0 (.clk(clk), .rst(rst), .cclk(cclk[0]), .convst_n(convst_n[0]),
        .cs_n(cs_n[0]), .rd_n(rd_n[0]), .byte_sel(byte_sel[0]), .stuck(stuck[0]),
        .code_i(code[0]), .busy(busy[0]), .db(db[0]), .nconv(nconv[0]));
    adc_beh_model u_adc1 (.clk(clk), .rst(rst), .cclk(cclk[1]), .convst_n(convst_n[1]),
        .cs_n(cs_n[1]), .rd_n(rd_n[1]), .byte_sel(byte_sel[1]), .stuck(stuck[1]),
        .code_i(code[1]), .busy(busy[1]), .db(db[1]), .nconv(nconv[1]));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int qsize(input int i);
        return (i == 0) ? q0.size() : q1.size();
    endfunction

    task automatic sb_pop(input int i, input logic [15:0] got);
        logic [15:0] e;
        if (qsize(i) == 0) begin
            chk(1'b0, "R7 valid with no pending expectation", {16'h0, got}, 32'h0);
        end else begin
            e = (i == 0) ? q0.pop_front() : q1.pop_front();
            chk(got == e, (i == 0) ? "R5 R7 word-mode sample" : "R6 R7 byte-mode sample",
                {16'h0, got}, {16'h0, e});
        end
    endtask

    // Monitor: protocol checks and scoreboard, sampled on falling edges.
    logic [1:0] prev_cv = '1, prev_rd = '1, prev_cs = '1;
    int low_run [2]  = '{0, 0};
    int since_rd [2] = '{1000, 1000};
    int since_cv [2] = '{1000, 1000};
    int rd_idx [2]   = '{0, 0};

    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 2; i++) begin
                if (prev_cv[i] && !convst_n[i]) begin
                    chk(!cs_n[i] && !prev_cs[i], "R2 chip-select low before strobe fall", {31'h0, cs_n[i]}, 32'h0);
                    chk(!busy[i], "R3 strobe fell while busy", {31'h0, busy[i]}, 32'h0);
                    chk(since_rd[i] >= GUARD, "R4 read strobe inside guard window", since_rd[i], GUARD);
                    rd_idx[i] = 0;
                end
                if (!prev_cv[i] && convst_n[i])
                    chk(low_run[i] == CLOW, "R2 strobe low width", low_run[i], CLOW);
                if (prev_rd[i] && !rd_n[i]) begin
                    chk(!busy[i], "R3 read began while busy", {31'h0, busy[i]}, 32'h0);
                    chk(since_cv[i] >= POST, "R4 read too soon after strobe", since_cv[i], POST);
                    chk(!cs_n[i], "R5 read without chip-select", {31'h0, cs_n[i]}, 32'h0);
                    if (i == 0)
                        chk(!byte_sel[i] && rd_idx[i] == 0, "R5 word mode single read with byte low",
                            {byte_sel[i], 31'(rd_idx[i])}, 32'h0);
                    else
                        chk(byte_sel[i] == rd_idx[i][0] && rd_idx[i] < 2, "R6 byte order low then high",
                            {31'h0, byte_sel[i]}, 32'(rd_idx[i]));
                    rd_idx[i] = rd_idx[i] + 1;
                end
                if (valid[i]) sb_pop(i, smp[i]);
                if (tmo[i]) tmo_cnt[i] = tmo_cnt[i] + 1;
                low_run[i]  = convst_n[i] ? 0 : low_run[i] + 1;
                since_rd[i] = rd_n[i] ? since_rd[i] + 1 : 0;
                since_cv[i] = convst_n[i] ? since_cv[i] + 1 : 0;
            end
        end
        prev_cv = convst_n;
        prev_rd = rd_n;
        prev_cs = cs_n;
    end

    // Driver: pushes the expected code and pulses a request.
    task automatic do_req(input int i, input bit expect_sample);
        @(negedge clk);
        if (expect_sample) begin
            if (i == 0) q0.push_back(code_of(nreq[0])); else q1.push_back(code_of(nreq[1]));
            nreq[i] = nreq[i] + 1;
        end
        req[i] = 1'b1;
        @(negedge clk);
        req[i] = 1'b0;
    endtask

    task automatic drain(input int i, input string tag);
        int n = 0;
        while (qsize(i) != 0 && n < 5000) begin @(negedge clk); n++; end
        repeat (GUARD + 4) @(negedge clk);
        chk(qsize(i) == 0, tag, qsize(i), 0);
    endtask

    task automatic wait_busy(input int i);
        int n = 0;
        while (!busy[i] && n < 500) begin @(negedge clk); n++; end
    endtask

    task automatic finish_run;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog expired", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R10: outputs while reset is held
        for (int i = 0; i < 2; i++)
            chk({convst_n[i], cs_n[i], rd_n[i], byte_sel[i], valid[i], tmo[i]} == 6'b111000,
                "R10 reset pin state", {convst_n[i], cs_n[i], rd_n[i], byte_sel[i], valid[i], tmo[i]}, 6'b111000);
        rst = 1'b0;
        @(negedge clk);
        chk({convst_n[0], cs_n[0], rd_n[0], valid[0]} == 4'b1110, "R10 state after reset",
            {convst_n[0], cs_n[0], rd_n[0], valid[0]}, 4'b1110);

        // R1: conversion clock period
        begin
            int t0, t1;
            while (cclk[0]) @(negedge clk);
            while (!cclk[0]) @(negedge clk);
            t0 = cyc;
            while (cclk[0]) @(negedge clk);
            while (!cclk[0]) @(negedge clk);
            t1 = cyc;
            chk(t1 - t0 == 2 * HALF, "R1 conversion clock period", t1 - t0, 2 * HALF);
        end

        // Word mode: boundary codes, one at a time
        for (int k = 0; k < 4; k++) begin
            do_req(0, 1'b1);
            drain(0, "R7 word sample delivered");
        end
        // R8: request during a conversion is held and served
        do_req(0, 1'b1);
        wait_busy(0);
        do_req(0, 1'b1);
        drain(0, "R8 pending request served in word mode");

        // Byte mode: boundary codes and a pending request
        for (int k = 0; k < 5; k++) begin
            do_req(1, 1'b1);
            drain(1, "R6 byte sample delivered");
        end
        do_req(1, 1'b1);
        wait_busy(1);
        do_req(1, 1'b1);
        drain(1, "R8 pending request served in byte mode");

        // R9: busy stuck high ends in a timeout pulse
        begin
            int n = 0, t_fall;
            stuck[0] = 1'b1;
            do_req(0, 1'b0);
            while (convst_n[0] && n < 200) begin @(negedge clk); n++; end
            t_fall = cyc;
            n = 0;
            while (!tmo[0] && n < 2000) begin @(negedge clk); n++; end
            chk(tmo[0] == 1'b1, "R9 timeout pulse raised", {31'h0, tmo[0]}, 1);
            chk((cyc - t_fall) >= (TMO - 1) * 2 * HALF && (cyc - t_fall) <= (TMO + 2) * 2 * HALF,
                "R9 timeout latency", cyc - t_fall, TMO * 2 * HALF);
            @(negedge clk);
            chk(tmo[0] == 1'b0, "R9 timeout is a single pulse", {31'h0, tmo[0]}, 0);
            stuck[0] = 1'b0;
            repeat (GUARD + 4) @(negedge clk);
            chk(tmo_cnt[0] == 1, "R9 one timeout counted", tmo_cnt[0], 1);
            do_req(0, 1'b1);
            drain(0, "R9 conversion works after timeout");
        end

        chk(tmo_cnt[1] == 0, "R9 no timeout on healthy converter", tmo_cnt[1], 0);
        finish_run();
    end
endmodule